// File: doc/BRIEF.md
# Seven-Slot Pixel Lane Serializer

This block turns one parallel video pixel per pixel period into serial bit streams for a low-voltage differential display link. It runs on a fast clock at seven times the pixel rate. A one-cycle strobe marks the fast cycle in which a new pixel is presented. On that edge the block captures the colour, sync and enable inputs together with the mapping select, and then shifts seven bit-slots per pixel out of each of four data lanes. It also produces a clock lane with a fixed seven-slot waveform.

Three bit-to-slot mappings can be selected. The 18-bit legacy map uses three data lanes and holds the fourth lane low. The 24-bit legacy map puts the upper six bits of each colour on lanes 0 to 2 and the two lowest bits on lane 3. The 24-bit alternate map keeps the 18-bit arrangement of the lower six bits on lanes 0 to 2 and carries the two top bits on lane 3. Output drivers, clock synthesis and panel timing generation belong to other blocks.

Top module: `pix7_serializer`

## Requirements
- R1: A pixel is captured on the rising edge where `pix_strobe` is 1. Slot k (k = 0..6) of every lane is driven on the outputs during the fast cycle that follows the (k+1)-th rising edge counted from that capture edge, so slots leave in order 0 to 6.
- R2: After the first capture, `clk_lane_o` follows the per-slot pattern 1,1,0,0,0,1,1 for slots 0 to 6.
- R3: With `mode_i` = 2'b00 (18-bit legacy), lane 0 carries G0,R5,R4,R3,R2,R1,R0 and lane 1 carries B1,B0,G5,G4,G3,G2,G1 in slots 0 to 6.
- R4: On lane 2, slot 0 carries data enable, slot 1 carries vertical sync and slot 2 carries horizontal sync in every mode. Slots 3 to 6 carry B5..B2 in the 18-bit and alternate maps and B7..B4 in the 24-bit legacy map.
- R5: In the 18-bit map lane 3 stays 0 in every slot, and colour bits 7 and 6 have no effect on any lane.
- R6: With `mode_i` = 2'b01 (24-bit legacy), lane 0 carries G2,R7..R2, lane 1 carries B3,B2,G7..G3, and lane 3 carries 0,B1,B0,G1,G0,R1,R0. Slot 0 of lane 3 is always 0.
- R7: With `mode_i` = 2'b10 (24-bit alternate), lanes 0 and 1 match R3 using colour bits 5..0, and lane 3 carries 0,B7,B6,G7,G6,R7,R6.
- R8: The unused code `mode_i` = 2'b11 is treated as the 18-bit map.
- R9: Changes to the pixel inputs or to `mode_i` in cycles without `pix_strobe` do not alter the pixel being shifted out.
- R10: A synchronous active-high `rst` drives all data lanes and the clock lane to 0 on the next edge. They stay 0 until the first capture after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast serial clock, seven cycles per pixel |
| rst | input | 1 | Synchronous reset, active high |
| pix_strobe | input | 1 | Marks the fast cycle carrying a new pixel (slot 0) |
| red_i | input | 8 | Red component |
| green_i | input | 8 | Green component |
| blue_i | input | 8 | Blue component |
| hsync_i | input | 1 | Horizontal sync |
| vsync_i | input | 1 | Vertical sync |
| de_i | input | 1 | Data enable |
| mode_i | input | 2 | Map select: 00 18-bit legacy, 01 24-bit legacy, 10 24-bit alternate, 11 as 00 |
| lane_o | output | 4 | Serial data lanes, bit n is lane n |
| clk_lane_o | output | 1 | Serial clock lane |

## Verification
The bench sends pixels with walking, all-ones and random colour values in every map. A design that swapped the two colour-field selections would show the low bits on lanes 0 to 2 in the 24-bit legacy map, and a design that reversed slot order would send R0 where G0 belongs. A pixel with only colour bits 7 and 6 set in the 18-bit map shows whether those bits leak onto any lane, and code 2'b11 shows whether the unused value falls into a 24-bit path and drives lane 3. Pixels whose inputs and mode are scrambled after capture would expose a design that reads live inputs instead of its captured words. A reset during active output, followed by idle cycles, would catch a clock lane that kept toggling before the next capture.

// File: rtl/pix7_pkg.sv
package pix7_pkg;
  localparam int SLOTS   = 7;
  localparam int LANES   = 4;
  localparam int COLOR_W = 8;
  localparam int FIELD_W = 6;
  localparam int SLOT_W  = $clog2(SLOTS);

  // bit k is the clock-lane level in slot k
  localparam logic [SLOTS-1:0] CLK_PATTERN = 7'b1100011;

  typedef enum logic [1:0] {
    MAP_18     = 2'b00,
    MAP_24_LEG = 2'b01,
    MAP_24_ALT = 2'b10
  } map_mode_e;

  typedef logic [SLOTS-1:0] slot_word_t;
endpackage

// File: rtl/pix7_slot_mapper.sv
module pix7_slot_mapper
  import pix7_pkg::*;
(
  input  logic [COLOR_W-1:0] red_i,
  input  logic [COLOR_W-1:0] green_i,
  input  logic [COLOR_W-1:0] blue_i,
  input  logic               hsync_i,
  input  logic               vsync_i,
  input  logic               de_i,
  input  logic [1:0]         mode_i,
  output logic [LANES-1:0][SLOTS-1:0] words_o
);
  localparam int EXTRA_W = COLOR_W - FIELD_W;

  logic                  use_high;
  logic                  use_lane3;
  logic [FIELD_W-1:0]    fr, fg, fb;
  logic [EXTRA_W-1:0]    xr, xg, xb;

  // 24-bit legacy places the top six bits on lanes 0..2; other maps the low six
  assign use_high  = (mode_i == MAP_24_LEG);
  assign use_lane3 = (mode_i == MAP_24_LEG) || (mode_i == MAP_24_ALT);

  assign fr = use_high ? red_i[COLOR_W-1:EXTRA_W]   : red_i[FIELD_W-1:0];
  assign fg = use_high ? green_i[COLOR_W-1:EXTRA_W] : green_i[FIELD_W-1:0];
  assign fb = use_high ? blue_i[COLOR_W-1:EXTRA_W]  : blue_i[FIELD_W-1:0];

  // the two colour bits left over go to the fourth lane
  assign xr = use_high ? red_i[EXTRA_W-1:0]   : red_i[COLOR_W-1:FIELD_W];
  assign xg = use_high ? green_i[EXTRA_W-1:0] : green_i[COLOR_W-1:FIELD_W];
  assign xb = use_high ? blue_i[EXTRA_W-1:0]  : blue_i[COLOR_W-1:FIELD_W];

  // each word is written {slot6 .. slot0}
  always_comb begin
    words_o[0] = {fr[0], fr[1], fr[2], fr[3], fr[4], fr[5], fg[0]};
    words_o[1] = {fg[1], fg[2], fg[3], fg[4], fg[5], fb[0], fb[1]};
    words_o[2] = {fb[2], fb[3], fb[4], fb[5], hsync_i, vsync_i, de_i};
    if (use_lane3)
      words_o[3] = {xr[0], xr[1], xg[0], xg[1], xb[0], xb[1], 1'b0};
    else
      words_o[3] = '0;
  end
endmodule

// File: rtl/pix7_lane_shifter.sv
module pix7_lane_shifter #(
  parameter int SLOTS = 7
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load_i,
  input  logic [SLOTS-1:0] word_i,
  output logic             bit_o
);
  logic [SLOTS-2:0] rest_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      rest_q <= '0;
      bit_o  <= 1'b0;
    end else if (load_i) begin
      bit_o  <= word_i[0];
      rest_q <= word_i[SLOTS-1:1];
    end else begin
      bit_o  <= rest_q[0];
      rest_q <= {1'b0, rest_q[SLOTS-2:1]};
    end
  end
endmodule

// File: rtl/pix7_slot_seq.sv
module pix7_slot_seq
  import pix7_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              strobe_i,
  output logic [SLOT_W-1:0] slot_o,
  output logic              clk_lane_o
);
  logic              active_q;
  logic [SLOT_W-1:0] slot_nxt;

  assign slot_nxt = (slot_o == SLOT_W'(SLOTS-1)) ? '0 : slot_o + 1'b1;

  always_ff @(posedge clk) begin
    if (rst) begin
      slot_o     <= '0;
      active_q   <= 1'b0;
      clk_lane_o <= 1'b0;
    end else if (strobe_i) begin
      slot_o     <= '0;
      active_q   <= 1'b1;
      clk_lane_o <= CLK_PATTERN[0];
    end else if (active_q) begin
      slot_o     <= slot_nxt;
      clk_lane_o <= CLK_PATTERN[slot_nxt];
    end
  end
endmodule

// File: rtl/pix7_serializer.sv
module pix7_serializer
  import pix7_pkg::*;
(
  input  logic               clk,
  input  logic               rst,
  input  logic               pix_strobe,
  input  logic [COLOR_W-1:0] red_i,
  input  logic [COLOR_W-1:0] green_i,
  input  logic [COLOR_W-1:0] blue_i,
  input  logic               hsync_i,
  input  logic               vsync_i,
  input  logic               de_i,
  input  logic [1:0]         mode_i,
  output logic [LANES-1:0]   lane_o,
  output logic               clk_lane_o
);
  logic [LANES-1:0][SLOTS-1:0] words;
  logic [SLOT_W-1:0]           slot_cur;

  pix7_slot_mapper map_i (
    .red_i   (red_i),
    .green_i (green_i),
    .blue_i  (blue_i),
    .hsync_i (hsync_i),
    .vsync_i (vsync_i),
    .de_i    (de_i),
    .mode_i  (mode_i),
    .words_o (words)
  );

  pix7_slot_seq seq_i (
    .clk        (clk),
    .rst        (rst),
    .strobe_i   (pix_strobe),
    .slot_o     (slot_cur),
    .clk_lane_o (clk_lane_o)
  );

  for (genvar ln = 0; ln < LANES; ln++) begin : g_lane
    pix7_lane_shifter #(.SLOTS(SLOTS)) shf_i (
      .clk    (clk),
      .rst    (rst),
      .load_i (pix_strobe),
      .word_i (words[ln]),
      .bit_o  (lane_o[ln])
    );
  end
endmodule

// File: rtl/pix7_serializer_chk.sv
module pix7_serializer_chk
  import pix7_pkg::*;
(
  input logic             clk,
  input logic             rst,
  input logic             pix_strobe,
  input logic             de_i,
  input logic [1:0]       mode_i,
  input logic [LANES-1:0] lane_o,
  input logic             clk_lane_o
);
  logic              seen_q;
  logic              narrow_q;
  logic [SLOT_W-1:0] cslot_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      seen_q   <= 1'b0;
      narrow_q <= 1'b0;
      cslot_q  <= '0;
    end else if (pix_strobe) begin
      seen_q   <= 1'b1;
      narrow_q <= (mode_i == MAP_18) || (mode_i == 2'b11);
      cslot_q  <= '0;
    end else if (seen_q) begin
      cslot_q  <= (cslot_q == SLOT_W'(SLOTS-1)) ? '0 : cslot_q + 1'b1;
    end
  end

  // R10: quiet outputs until the first capture after reset
  p_quiet_after_reset_r10: assert property (@(posedge clk) disable iff (rst)
    !seen_q |-> (lane_o == '0 && !clk_lane_o));

  // R2: clock lane level follows the slot pattern
  p_clk_pattern_r2: assert property (@(posedge clk) disable iff (rst)
    seen_q |-> (clk_lane_o == CLK_PATTERN[cslot_q]));

  // R4: data enable leaves in slot 0 of lane 2
  p_ctl_de_r4: assert property (@(posedge clk) disable iff (rst)
    pix_strobe |=> (lane_o[2] == $past(de_i)));

  // R5: fourth lane idle in the 18-bit map
  p_lane3_idle_r5: assert property (@(posedge clk) disable iff (rst)
    (seen_q && narrow_q) |-> !lane_o[3]);

  // R6: the fixed-zero control slot on lane 3
  p_ctl3_zero_r6: assert property (@(posedge clk) disable iff (rst)
    (seen_q && cslot_q == '0) |-> !lane_o[3]);
endmodule

bind pix7_serializer pix7_serializer_chk chk_i (
  .clk        (clk),
  .rst        (rst),
  .pix_strobe (pix_strobe),
  .de_i       (de_i),
  .mode_i     (mode_i),
  .lane_o     (lane_o),
  .clk_lane_o (clk_lane_o)
);

// File: tb/pix7_serializer_tb_top.sv
module pix7_serializer_tb_top;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       pix_strobe = 1'b0;
  logic [7:0] red_i = '0, green_i = '0, blue_i = '0;
  logic       hsync_i = 1'b0, vsync_i = 1'b0, de_i = 1'b0;
  logic [1:0] mode_i = 2'b00;
  logic [3:0] lane_o;
  logic       clk_lane_o;

  int n_checks = 0;
  int n_errors = 0;
  bit finished = 0;

  typedef struct {
    logic [4:0] v;   // {clk_lane, lane3, lane2, lane1, lane0}
    string      tag;
  } exp_item_t;

  exp_item_t sb_q[$];

  always #10 clk = ~clk;

  pix7_serializer dut_i (
    .clk(clk), .rst(rst), .pix_strobe(pix_strobe),
    .red_i(red_i), .green_i(green_i), .blue_i(blue_i),
    .hsync_i(hsync_i), .vsync_i(vsync_i), .de_i(de_i),
    .mode_i(mode_i), .lane_o(lane_o), .clk_lane_o(clk_lane_o)
  );

  function automatic logic [4:0] exp_bits(input logic [1:0] m,
      input logic [7:0] r, input logic [7:0] g, input logic [7:0] b,
      input logic h, input logic v, input logic d, input int s);
    logic leg, alt, l0, l1, l2, l3, ck;
    leg = (m == 2'b01);
    alt = (m == 2'b10);
    l0 = (s == 0) ? (leg ? g[2] : g[0]) : (leg ? r[8-s] : r[6-s]);
    if (s == 0)      l1 = leg ? b[3] : b[1];
    else if (s == 1) l1 = leg ? b[2] : b[0];
    else             l1 = leg ? g[9-s] : g[7-s];
    case (s)
      0: l2 = d;
      1: l2 = v;
      2: l2 = h;
      default: l2 = leg ? b[10-s] : b[8-s];
    endcase
    l3 = 1'b0;
    if (leg || alt) begin
      case (s)
        1: l3 = leg ? b[1] : b[7];
        2: l3 = leg ? b[0] : b[6];
        3: l3 = leg ? g[1] : g[7];
        4: l3 = leg ? g[0] : g[6];
        5: l3 = leg ? r[1] : r[7];
        6: l3 = leg ? r[0] : r[6];
        default: l3 = 1'b0;
      endcase
    end
    ck = (s <= 1) || (s >= 5);
    return {ck, l3, l2, l1, l0};
  endfunction

  task automatic check_bits(input logic [4:0] got, input logic [4:0] exp,
                            input string tag);
    n_checks++;
    if (got !== exp) begin
      n_errors++;
      $display("FAIL %s: got %b expected %b at %0t", tag, got, exp, $time);
    end
  endtask

  task automatic send_pixel(input logic [1:0] m, input logic [7:0] r,
      input logic [7:0] g, input logic [7:0] b, input logic h, input logic v,
      input logic d, input bit scramble, input string tag);
    @(negedge clk);
    mode_i = m; red_i = r; green_i = g; blue_i = b;
    hsync_i = h; vsync_i = v; de_i = d; pix_strobe = 1'b1;
    for (int s = 0; s < 7; s++)
      sb_q.push_back('{exp_bits(m, r, g, b, h, v, d, s), tag});
    for (int k = 1; k < 7; k++) begin
      @(negedge clk);
      pix_strobe = 1'b0;
      if (scramble) begin
        red_i = 8'($urandom); green_i = 8'($urandom); blue_i = 8'($urandom);
        hsync_i = 1'($urandom); vsync_i = 1'($urandom); de_i = 1'($urandom);
        mode_i = 2'($urandom);
      end
    end
  endtask

  // monitor: compare each slot as it leaves
  initial begin
    forever begin
      @(posedge clk);
      #5;
      if (sb_q.size() > 0) begin
        exp_item_t it;
        it = sb_q.pop_front();
        check_bits({clk_lane_o, lane_o}, it.v, it.tag);
      end
    end
  end

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_errors++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(posedge clk);
    #5;
    check_bits({clk_lane_o, lane_o}, 5'b0, "R10 reset state");
    @(negedge clk);
    rst = 1'b0;
    for (int i = 0; i < 9; i++) begin
      @(posedge clk);
      #5;
      check_bits({clk_lane_o, lane_o}, 5'b0, "R10 idle before first capture");
    end

    // R1 R3 R4: walking patterns in the 18-bit map
    send_pixel(2'b00, 8'h01, 8'h00, 8'h00, 1'b0, 1'b0, 1'b1, 0, "R1 R3 r0 bit");
    send_pixel(2'b00, 8'h00, 8'h01, 8'h00, 1'b1, 1'b0, 1'b0, 0, "R3 g0 bit hsync R4");
    send_pixel(2'b00, 8'h00, 8'h00, 8'h02, 1'b0, 1'b1, 1'b0, 0, "R3 b1 bit vsync R4");
    send_pixel(2'b00, 8'h3f, 8'h3f, 8'h3f, 1'b1, 1'b1, 1'b1, 0, "R3 all low six");
    // R5: top colour bits have no effect in the 18-bit map
    send_pixel(2'b00, 8'hc0, 8'hc0, 8'hc0, 1'b0, 1'b0, 1'b0, 0, "R5 top bits ignored");
    send_pixel(2'b00, 8'hd5, 8'h6a, 8'hb3, 1'b0, 1'b1, 1'b1, 0, "R5 lane3 idle");
    // R6: 24-bit legacy
    send_pixel(2'b01, 8'h80, 8'h04, 8'h08, 1'b0, 1'b0, 1'b1, 0, "R6 r7 g2 b3");
    send_pixel(2'b01, 8'h03, 8'h03, 8'h03, 1'b1, 1'b1, 1'b1, 0, "R6 lane3 low bits");
    send_pixel(2'b01, 8'hff, 8'hff, 8'hff, 1'b1, 1'b1, 1'b1, 0, "R6 all ones");
    send_pixel(2'b01, 8'h5a, 8'ha5, 8'h3c, 1'b1, 1'b0, 1'b1, 0, "R4 R6 mixed");
    // R7: 24-bit alternate
    send_pixel(2'b10, 8'hc0, 8'h40, 8'h80, 1'b0, 1'b0, 1'b1, 0, "R7 lane3 top bits");
    send_pixel(2'b10, 8'h3f, 8'h00, 8'h3f, 1'b1, 1'b0, 1'b0, 0, "R7 low six");
    send_pixel(2'b10, 8'hff, 8'hff, 8'hff, 1'b1, 1'b1, 1'b1, 0, "R7 all ones");
    // R8: unused code behaves as the 18-bit map
    send_pixel(2'b11, 8'hff, 8'hff, 8'hff, 1'b1, 1'b1, 1'b1, 0, "R8 code 3 as 18-bit");
    send_pixel(2'b11, 8'hc3, 8'h81, 8'h42, 1'b0, 1'b1, 1'b0, 0, "R8 code 3 mixed");
    // R9: inputs scrambled after capture
    for (int i = 0; i < 12; i++)
      send_pixel(2'(i % 3), 8'($urandom), 8'($urandom), 8'($urandom),
                 1'($urandom), 1'($urandom), 1'($urandom), 1, "R9 mid-pixel change");
    // random back-to-back traffic in all modes
    for (int i = 0; i < 20; i++)
      send_pixel(2'($urandom), 8'($urandom), 8'($urandom), 8'($urandom),
                 1'($urandom), 1'($urandom), 1'($urandom), 0, "R1 random stream");

    wait (sb_q.size() == 0);
    @(posedge clk);
    // reset while the clock lane is still running
    @(negedge clk);
    rst = 1'b1;
    @(posedge clk);
    #5;
    check_bits({clk_lane_o, lane_o}, 5'b0, "R10 reset during output");
    @(negedge clk);
    rst = 1'b0;
    for (int i = 0; i < 10; i++) begin
      @(posedge clk);
      #5;
      check_bits({clk_lane_o, lane_o}, 5'b0, "R10 quiet after reset");
    end
    send_pixel(2'b01, 8'h96, 8'h69, 8'hf0, 1'b1, 1'b0, 1'b1, 0, "R10 first pixel after reset");
    wait (sb_q.size() == 0);
    repeat (2) @(posedge clk);
    finish_run();
  end
endmodule